// File: doc/BRIEF.md
# Masked Priority Interrupt Encoder

This block gathers a set of level-sensitive interrupt request lines into a status register, qualifies them with a writable enable mask and raises a single combined interrupt whenever any enabled request is active. Software services the interrupt by reading a vector register. That register encodes the lowest-numbered source that is both active and enabled. The encoding is the source index plus one, shifted left by two, so a value of zero always means that nothing is pending.

Software reaches the block through a small register port with a 16-bit data path. The vector sits at offset 0 and is read-only. The mask sits at offset 2 and can be read and written. Any other offset reads as zero and ignores writes. The source count, data width, address width, offsets, reset mask and the encoder structure are all parameters. One parameter selects between two encoder structures that produce identical results.

Top module: `masked_irq_encoder`

## Requirements
- R1: Each status bit follows the level of its request input as sampled at every rising clock edge: set while the input is high, cleared once it is low.
- R2: `irq_o` is high exactly when status AND mask is nonzero, and it is registered, so it reflects a request change at the first rising edge after that change.
- R3: A read at offset 0 returns ((n+1) << 2), where n is the lowest-numbered bit set in status AND mask, and returns 0 when no bit is set; bits [1:0] of the vector are always zero.
- R4: A write at offset 2 loads the mask from the low NUM_SRC data bits at the rising edge, and a read at offset 2 returns the mask zero-extended to the data width.
- R5: A mask write re-evaluates `irq_o` and the vector at the same edge that loads the mask, with no extra latency.
- R6: While reset is asserted and after it is released, the mask is 0x0010, the status is zero, `irq_o` is low and the vector reads 0.
- R7: Reads at any offset other than 0 or 2 return zero, and writes to those offsets, including offset 0, leave the mask and `irq_o` unchanged.
- R8: A request whose mask bit is clear contributes nothing to the vector or to `irq_o`, even when it has a lower index than an enabled pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Level-sensitive interrupt requests, bit i is source i |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, acts at the rising edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational from registered state |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds two instances with the default sixteen sources, 16-bit data and a 4-bit address. One instance uses the scanning encoder and the other uses the lowest-bit isolating encoder, and both are checked against the same expected vectors. With sixteen sources the largest vector, 0x40, and every single-source code can be reached directly. The 4-bit address also reaches the odd offsets and the offsets above 2, which lets the bench check the reads that return zero and the writes that must be ignored.

// File: rtl/mpie_pkg.sv
package mpie_pkg;

   // Structure of the lowest-index priority encoder
   typedef enum logic [0:0] {
      ENC_SCAN    = 1'b0,   // ordered scan, lowest index wins
      ENC_ISOLATE = 1'b1    // isolate lowest set bit, then OR-encode
   } enc_style_e;

   // Vector code for a zero-based source index
   function automatic int unsigned vec_code(input int unsigned idx);
      return (idx + 1) << 2;
   endfunction

endpackage

// File: rtl/mpie_sampler.sv
module mpie_sampler #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] mask_nxt_i,
   output logic [NUM_SRC-1:0] status_o,
   output logic               irq_o
);

   logic [NUM_SRC-1:0] status_q;
   logic               irq_q;

   // irq is computed from the next-state status and mask, so it stays
   // aligned with the registered status and mask that feed the vector
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= req_i;
         irq_q    <= |(req_i & mask_nxt_i);
      end
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;

endmodule

// File: rtl/mpie_prio_enc.sv
module mpie_prio_enc #(
   parameter int                  NUM_SRC = 16,
   parameter int                  DATA_W  = 16,
   parameter mpie_pkg::enc_style_e STYLE  = mpie_pkg::ENC_SCAN
) (
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [DATA_W-1:0]  vec_o
);

   localparam int IDX_W = $clog2(NUM_SRC + 1);

   logic [IDX_W-1:0] code;

   generate
      if (STYLE == mpie_pkg::ENC_SCAN) begin : g_scan
         always_comb begin
            code = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
               if (pend_i[i]) code = IDX_W'(i + 1);
            end
         end
      end else begin : g_isolate
         logic [NUM_SRC-1:0] lowest;
         assign lowest = pend_i & (~pend_i + NUM_SRC'(1));
         always_comb begin
            code = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
               if (lowest[i]) code = code | IDX_W'(i + 1);
            end
         end
      end
   endgenerate

   assign vec_o = DATA_W'(code) << 2;

endmodule

// File: rtl/mpie_regs.sv
module mpie_regs #(
   parameter int                 NUM_SRC    = 16,
   parameter int                 DATA_W     = 16,
   parameter int                 ADDR_W     = 4,
   parameter int                 VEC_OFS    = 0,
   parameter int                 MASK_OFS   = 2,
   parameter logic [NUM_SRC-1:0] MASK_RESET = NUM_SRC'(16'h0010)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [DATA_W-1:0]  vec_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] mask_nxt_o,
   output logic [DATA_W-1:0]  rdata_o
);

   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_OFS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

   logic [NUM_SRC-1:0] mask_q;
   logic               mask_hit;

   assign mask_hit   = wr_en_i && (addr_i == A_MASK);
   assign mask_nxt_o = !rst_n   ? MASK_RESET :
                       mask_hit ? wdata_i[NUM_SRC-1:0] : mask_q;

   always_ff @(posedge clk) begin
      mask_q <= mask_nxt_o;
   end

   always_comb begin
      if (addr_i == A_VEC)       rdata_o = vec_i;
      else if (addr_i == A_MASK) rdata_o = DATA_W'(mask_q);
      else                       rdata_o = '0;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/masked_irq_encoder.sv
module masked_irq_encoder #(
   parameter int                   NUM_SRC    = 16,
   parameter int                   DATA_W     = 16,
   parameter int                   ADDR_W     = 4,
   parameter int                   VEC_OFS    = 0,
   parameter int                   MASK_OFS   = 2,
   parameter logic [NUM_SRC-1:0]   MASK_RESET = NUM_SRC'(16'h0010),
   parameter mpie_pkg::enc_style_e ENC_STYLE  = mpie_pkg::ENC_SCAN
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr_en,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_o
);

   localparam int IDX_W = $clog2(NUM_SRC + 1);

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must be between 1 and DATA_W");
      end
      if (IDX_W + 2 > DATA_W) begin : g_bad_vec
         $error("vector code does not fit in DATA_W");
      end
      if (VEC_OFS == MASK_OFS) begin : g_bad_ofs
         $error("vector and mask offsets must differ");
      end
      if (VEC_OFS >= (1 << ADDR_W) || MASK_OFS >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register offsets exceed ADDR_W");
      end
   endgenerate

   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] mask_nxt;
   logic [NUM_SRC-1:0] pend;
   logic [DATA_W-1:0]  vec;

   mpie_sampler #(.NUM_SRC(NUM_SRC)) u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (irq_req),
      .mask_nxt_i (mask_nxt),
      .status_o   (status_q),
      .irq_o      (irq_o)
   );

   assign pend = status_q & mask_q;

   mpie_prio_enc #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .STYLE   (ENC_STYLE)
   ) u_enc (
      .pend_i (pend),
      .vec_o  (vec)
   );

   mpie_regs #(
      .NUM_SRC    (NUM_SRC),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .VEC_OFS    (VEC_OFS),
      .MASK_OFS   (MASK_OFS),
      .MASK_RESET (MASK_RESET)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (reg_addr),
      .wr_en_i    (reg_wr_en),
      .wdata_i    (reg_wdata),
      .vec_i      (vec),
      .mask_o     (mask_q),
      .mask_nxt_o (mask_nxt),
      .rdata_o    (reg_rdata)
   );

endmodule

// File: rtl/masked_irq_encoder_chk.sv
module masked_irq_encoder_chk #(
   parameter int                 NUM_SRC    = 16,
   parameter int                 DATA_W     = 16,
   parameter int                 ADDR_W     = 4,
   parameter int                 VEC_OFS    = 0,
   parameter int                 MASK_OFS   = 2,
   parameter logic [NUM_SRC-1:0] MASK_RESET = NUM_SRC'(16'h0010)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_req,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_wr_en,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] mask_q
);

   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_OFS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

   assert_status_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> status_q == $past(irq_req));

   assert_irq_matches_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|(status_q & mask_q)));

   assert_irq_agrees_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_VEC) |-> (irq_o == (reg_rdata != '0)));

   assert_vec_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_VEC) |-> (reg_rdata[1:0] == 2'b00));

   assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == A_MASK) |=> mask_q == $past(reg_wdata[NUM_SRC-1:0]));

   assert_other_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !(reg_wr_en && reg_addr == A_MASK)) |=> $stable(mask_q));

   assert_reset_state_R6: assert property (@(posedge clk)
      !rst_n |=> (mask_q == MASK_RESET && status_q == '0 && !irq_o));

endmodule

bind masked_irq_encoder masked_irq_encoder_chk #(
   .NUM_SRC    (NUM_SRC),
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .VEC_OFS    (VEC_OFS),
   .MASK_OFS   (MASK_OFS),
   .MASK_RESET (MASK_RESET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .reg_addr  (reg_addr),
   .reg_wr_en (reg_wr_en),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .status_q  (status_q),
   .mask_q    (mask_q)
);

// File: tb/tb_masked_irq_encoder.sv
module tb_masked_irq_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 16;
   localparam int DW  = 16;
   localparam int AW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr_en = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] rdata_a, rdata_b;
   logic          irq_a, irq_b;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   masked_irq_encoder #(.ENC_STYLE(mpie_pkg::ENC_SCAN)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_o(irq_a)
   );

   masked_irq_encoder #(.ENC_STYLE(mpie_pkg::ENC_ISOLATE)) dut_iso (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq_o(irq_b)
   );

   // expected model, written from the requirements
   logic [N-1:0] m_req  = '0;
   logic [N-1:0] m_mask = 16'h0010;

   function automatic logic [DW-1:0] exp_vec(input logic [N-1:0] r, input logic [N-1:0] m);
      logic [N-1:0] p = r & m;
      for (int i = 0; i < N; i++) if (p[i]) return DW'((i + 1) << 2);
      return '0;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // read at the current point (after a falling edge)
   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] va, output logic [DW-1:0] vb);
      reg_addr = a;
      #1;
      va = rdata_a;
      vb = rdata_b;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      if (a == AW'(2)) m_mask = d[N-1:0];
   endtask

   task automatic set_req(input logic [N-1:0] v);
      @(negedge clk);
      irq_req = v;
      m_req   = v;
      @(negedge clk);
   endtask

   task automatic chk_state(input string req);
      logic [DW-1:0] va, vb;
      logic [DW-1:0] e = exp_vec(m_req, m_mask);
      rd(AW'(0), va, vb);
      chk(req, "vector scan", va, e);
      chk(req, "vector isolate", vb, e);
      chk(req, "irq scan", irq_a, (e != 0));
      chk(req, "irq isolate", irq_b, (e != 0));
   endtask

   task automatic t_reset();
      logic [DW-1:0] va, vb;
      chk_state("R6");
      rd(AW'(2), va, vb);
      chk("R6", "mask reset", va, 32'h0010);
      chk("R6", "mask reset iso", vb, 32'h0010);
   endtask

   task automatic t_default_mask();
      set_req(16'h0010);          // R6 default mask enables source 4 -> 0x14
      chk_state("R6");
      chk("R3", "src4 code", rdata_a, 32'h14);
      set_req(16'h000F);          // R8 masked-off lower sources
      chk_state("R8");
      chk("R8", "irq low", irq_a, 0);
      set_req(16'h0000);
   endtask

   task automatic t_each_source();
      wr(AW'(2), 16'hFFFF);
      for (int i = 0; i < N; i++) begin
         set_req(N'(1) << i);
         chk_state("R3");
      end
      chk("R3", "top code", rdata_a, 32'h40);
      set_req('0);
      chk_state("R1");            // level low clears status
   endtask

   task automatic t_lowest_wins();
      logic [N-1:0] pats [6] = '{16'hFFFF, 16'h8001, 16'hA000, 16'h0300, 16'h8000, 16'h0F00};
      for (int k = 0; k < 6; k++) begin
         set_req(pats[k]);
         chk_state("R3");
      end
      set_req('0);
   endtask

   task automatic t_registered_irq();
      // drive request and look before and after the first edge
      @(negedge clk);
      irq_req = 16'h0004; m_req = 16'h0004;
      #1;
      chk("R2", "irq before edge", irq_a, 0);
      @(negedge clk);
      chk("R2", "irq after edge", irq_a, 1);
      chk("R1", "status set", rdata_a, 32'hC);
      set_req(16'h0000);
      chk("R2", "irq cleared", irq_a, 0);
   endtask

   task automatic t_mask_filter();
      wr(AW'(2), 16'hF0F0);
      set_req(16'h0F0F);
      chk_state("R8");
      set_req(16'h0F8F);          // bit 7 enabled -> 0x20
      chk_state("R8");
      wr(AW'(2), 16'h0001);       // R5 mask write retargets at same edge
      chk_state("R5");
      chk("R5", "vec after mask", rdata_a, 32'h4);
      wr(AW'(2), 16'h0000);
      chk_state("R5");
      chk("R5", "irq off", irq_a, 0);
   endtask

   task automatic t_mask_rw();
      logic [DW-1:0] va, vb;
      wr(AW'(2), 16'h5AA5);
      rd(AW'(2), va, vb);
      chk("R4", "mask readback", va, 32'h5AA5);
      chk("R4", "mask readback iso", vb, 32'h5AA5);
   endtask

   task automatic t_bad_offsets();
      logic [DW-1:0] va, vb;
      set_req(16'h0020);          // mask 0x5AA5 bit5 set -> 0x18
      for (int a = 0; a < (1 << AW); a++) begin
         if (a != 0 && a != 2) begin
            rd(AW'(a), va, vb);
            chk("R7", $sformatf("read ofs %0d", a), va, 0);
         end
      end
      for (int a = 0; a < (1 << AW); a++) begin
         if (a != 2) wr(AW'(a), 16'h0000);
      end
      rd(AW'(2), va, vb);
      chk("R7", "mask kept", va, 32'h5AA5);
      chk_state("R7");
      chk("R7", "irq kept", irq_a, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_mask();
      t_each_source();
      t_lowest_wins();
      t_registered_irq();
      t_mask_filter();
      t_mask_rw();
      t_bad_offsets();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule